// File: doc/BRIEF.md
# DDR2 Extended Mode Register Write Sequencer

This block sits beside the command scheduler of a DDR2 controller and turns a request carrying the first extended mode register settings into one register-write command on the DRAM command and address pins. The settings are DLL on/off, output driver strength, on-die termination value, additive latency, OCD calibration mode, DQS# disable and output-off. The block accepts a request only while all banks are precharged and CKE is high. It drives the command for one cycle and then blocks further commands until the mode-register cycle time has passed.

Two orderings are enforced on top of the field packing. A write that selects the OCD calibration default is followed automatically by a second write that exits calibration. An adjust-mode write reuses the additive latency that was last programmed. A read-permit output stays low after every DLL enable, whether the enable comes from a register write or from leaving self refresh, until the DLL has had `DLL_LOCK` cycles to lock.

The control is a three-state machine. `ST_IDLE` waits for an acceptable request. `ST_DFLT_HOLD` counts out the mode-register time after a calibration-default write. `ST_HOLD` counts out the mode-register time after any other write. The transitions are:
- `ST_IDLE` to `ST_HOLD` on an issued write.
- `ST_IDLE` to `ST_DFLT_HOLD` on an issued calibration-default write.
- `ST_DFLT_HOLD` to `ST_HOLD` when the count ends; the automatic exit write is issued on this transition.
- `ST_HOLD` to `ST_IDLE` when the count ends.

Top module: `emr_seq`

## Requirements
- R1: The write command drives cs_n, ras_n, cas_n and we_n low with ba = 2'b01 for exactly one cycle. In every other cycle the pins show NOP: cs_n low, ras_n, cas_n and we_n high, and ba and addr all zero.
- R2: Field positions on addr during a write:
  - addr[0] = DLL disable.
  - addr[1] = reduced driver strength.
  - {addr[6], addr[2]} = termination code (00 off, 01 75 ohm, 10 150 ohm, 11 50 ohm).
  - addr[5:3] = additive latency.
  - addr[9:7] = OCD code (000 exit, 001 drive-one, 010 drive-zero, 100 adjust, 111 default).
  - addr[10] = DQS# disable.
  - addr[12] = output buffers off.
  - addr[8] carries OCD bit 1; addr[11] and all bits above 12 are zero.
- R3: req_ready is high only in ST_IDLE with banks_idle and cke both high. A request is taken on a clock edge where req_valid and req_ready are both high; at any other time it is held off and no command appears.
- R4: A write taken on edge k appears on the pins in the following cycle c. The next write can appear no earlier than cycle c + T_MRD, and req_ready stays low until then.
- R5: A request whose latency field is 6 or 7 and whose OCD code is not adjust is taken but not issued. req_err pulses for the one cycle after acceptance, and the pins stay NOP.
- R6: After a write with OCD code 111 appears in cycle c, an automatic write appears in cycle c + T_MRD. It carries the same fields with OCD code 000. req_ready stays low until T_MRD cycles after that second write.
- R7: A write with OCD code 100 ignores the request's latency field and carries the latency of the last issued write (0 after reset).
- R8: When a write with addr[0] = 0 appears in cycle c while the DLL is considered off, rd_permit goes high in cycle c + DLL_LOCK and not earlier.
- R9: sr_enter high in a cycle makes rd_permit low from the next cycle. sr_exit high in cycle s, when the last write enabled the DLL, makes rd_permit go high in cycle s + DLL_LOCK.
- R10: After reset the pins show NOP, req_err and rd_permit are low, and the DLL is considered off.
- R11: A write with addr[0] = 1 makes rd_permit low from the cycle after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_dll_off | input | 1 | 1 disables the DLL |
| req_half_drv | input | 1 | 1 selects reduced driver strength |
| req_term | input | 2 | Termination code |
| req_al | input | 3 | Additive latency 0..5 |
| req_ocd | input | 3 | OCD calibration code |
| req_dqsn_off | input | 1 | 1 disables DQS# |
| req_qoff | input | 1 | 1 turns output buffers off |
| banks_idle | input | 1 | All banks precharged |
| cke | input | 1 | Clock enable already high |
| sr_enter | input | 1 | Self-refresh entry pulse |
| sr_exit | input | 1 | Self-refresh exit pulse |
| req_err | output | 1 | Reserved-latency rejection pulse |
| rd_permit | output | 1 | Reads allowed (DLL locked) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address pins carrying the register value |

## Verification
A behavioural model in the bench predicts every pin and flag on every cycle while the request stream changes shape:
- A plain write with mixed field values separates the bit positions from one another.
- A request held off first by busy banks and then by low CKE shows that no command leaks out early.
- Back-to-back requests pin down the exact tMRD spacing.
- Reserved latencies 6 and 7 separate rejection from issue.
- A calibration-default write exposes the timing and content of the automatic exit.
- An adjust write with a reserved latency shows that the stored latency replaces the request's.
- DLL disable, re-enable and self-refresh entry and exit check the lock window edge exactly.

// File: rtl/emr_pkg.sv
package emr_pkg;

    localparam int EMR_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_DFLT_HOLD = 2'd1,
        ST_HOLD      = 2'd2
    } emr_state_e;

    typedef struct packed {
        logic       qoff;
        logic       dqsn_off;
        logic [2:0] ocd;
        logic [2:0] al;
        logic [1:0] term;
        logic       half_drv;
        logic       dll_off;
    } emr_cfg_t;

    localparam logic [2:0] OCD_EXIT = 3'b000;
    localparam logic [2:0] OCD_ADJ  = 3'b100;
    localparam logic [2:0] OCD_DFLT = 3'b111;
    localparam logic [2:0] AL_MAX   = 3'd5;
    localparam logic [1:0] BA_EMR1  = 2'b01;

    // Place each setting on the address pin the DRAM decodes it from.
    function automatic logic [EMR_W-1:0] emr_pack(input emr_cfg_t c);
        logic [EMR_W-1:0] a;
        a      = '0;
        a[0]   = c.dll_off;
        a[1]   = c.half_drv;
        a[2]   = c.term[0];
        a[6]   = c.term[1];
        a[5:3] = c.al;
        a[9:7] = c.ocd;
        a[10]  = c.dqsn_off;
        a[12]  = c.qoff;
        return a;
    endfunction

endpackage

// File: rtl/emr_fsm.sv
module emr_fsm
    import emr_pkg::*;
#(
    parameter int T_MRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic banks_idle,
    input  logic cke,
    input  logic al_bad,
    input  logic is_dflt,
    output logic ready_o,
    output logic fire_new,
    output logic fire_exit,
    output logic err
);

    localparam int CW = (T_MRD > 1) ? $clog2(T_MRD) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(T_MRD - 1);

    emr_state_e state, nxt;
    logic [CW-1:0] cnt;
    logic load, accept, cnt_zero;

    always_comb begin
        cnt_zero  = (cnt == '0);
        ready_o   = (state == ST_IDLE) && banks_idle && cke;
        accept    = req_valid && ready_o;
        fire_new  = accept && !al_bad;
        fire_exit = 1'b0;
        load      = 1'b0;
        nxt       = state;
        unique case (state)
            ST_IDLE: begin
                if (fire_new) begin
                    nxt  = is_dflt ? ST_DFLT_HOLD : ST_HOLD;
                    load = 1'b1;
                end
            end
            ST_DFLT_HOLD: begin
                if (cnt_zero) begin
                    fire_exit = 1'b1;
                    nxt       = ST_HOLD;
                    load      = 1'b1;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= load ? CNT_LOAD : (cnt_zero ? cnt : cnt - 1'b1);
            err   <= accept && al_bad;
        end
    end

    assert_busy_no_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_new |=> !ready_o);

    assert_reject_no_issue_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !$past(fire_new));

    assert_exit_then_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_exit |=> (state == ST_HOLD) && !fire_exit);

endmodule

// File: rtl/emr_drv.sv
module emr_drv
    import emr_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_new,
    input  logic              fire_exit,
    input  emr_cfg_t          req_cfg,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    localparam emr_cfg_t CFG_RST = '{qoff: 1'b0, dqsn_off: 1'b0, ocd: OCD_EXIT,
                                     al: 3'd0, term: 2'd0, half_drv: 1'b0, dll_off: 1'b1};

    emr_cfg_t held, new_cfg, exit_cfg, cfg_sel;
    logic fire, mrs;

    always_comb begin
        new_cfg = req_cfg;
        if (req_cfg.ocd == OCD_ADJ) new_cfg.al = held.al;   // adjust keeps stored latency
        exit_cfg     = held;
        exit_cfg.ocd = OCD_EXIT;
        fire         = fire_new || fire_exit;
        cfg_sel      = fire_new ? new_cfg : exit_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held  <= CFG_RST;
            cs_n  <= 1'b0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            ba    <= '0;
            addr  <= '0;
        end else begin
            cs_n  <= 1'b0;
            ras_n <= !fire;
            cas_n <= !fire;
            we_n  <= !fire;
            ba    <= fire ? BA_EMR1 : 2'b00;
            addr  <= fire ? ADDR_W'(emr_pack(cfg_sel)) : '0;
            if (fire) held <= cfg_sel;
        end
    end

    assign mrs = !cs_n && !ras_n && !cas_n && !we_n;

    assert_target_emr1_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mrs |-> ba == BA_EMR1);

    assert_nop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mrs |-> (!cs_n && ras_n && cas_n && we_n && ba == 2'b00 && addr == '0));

    assert_field_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mrs |-> (addr[5:3] <= AL_MAX && addr[11] == 1'b0));

endmodule

// File: rtl/emr_dll.sv
module emr_dll #(
    parameter int DLL_LOCK = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic wr_dll_off,
    input  logic sr_enter,
    input  logic sr_exit,
    output logic rd_permit
);

    localparam int LW = $clog2(DLL_LOCK + 1);
    localparam logic [LW-1:0] LOCK_LOAD = LW'(DLL_LOCK - 1);

    logic          dll_on, prog_en;
    logic [LW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_on  <= 1'b0;
            prog_en <= 1'b0;
            cnt     <= '0;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (sr_enter) begin
                dll_on <= 1'b0;
            end else if (sr_exit && prog_en) begin
                dll_on <= 1'b1;
                cnt    <= LOCK_LOAD;
            end else if (wr) begin
                prog_en <= !wr_dll_off;
                if (wr_dll_off) begin
                    dll_on <= 1'b0;
                end else if (!dll_on) begin
                    dll_on <= 1'b1;
                    cnt    <= LOCK_LOAD;
                end
            end
        end
    end

    assign rd_permit = dll_on && (cnt == '0);

    assert_sr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter |=> !rd_permit);

    assert_disable_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wr_dll_off && !sr_exit) |=> !rd_permit);

    assert_lock_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_permit) |-> (DLL_LOCK < 2 || $past(cnt) == LW'(1)));

endmodule

// File: rtl/emr_seq.sv
module emr_seq
    import emr_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int T_MRD    = 2,
    parameter int DLL_LOCK = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_dll_off,
    input  logic              req_half_drv,
    input  logic [1:0]        req_term,
    input  logic [2:0]        req_al,
    input  logic [2:0]        req_ocd,
    input  logic              req_dqsn_off,
    input  logic              req_qoff,
    input  logic              banks_idle,
    input  logic              cke,
    input  logic              sr_enter,
    input  logic              sr_exit,
    output logic              req_err,
    output logic              rd_permit,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);

    emr_cfg_t cfg;
    logic al_bad, is_dflt, fire_new, fire_exit, wr_seen;

    always_comb begin
        cfg.qoff     = req_qoff;
        cfg.dqsn_off = req_dqsn_off;
        cfg.ocd      = req_ocd;
        cfg.al       = req_al;
        cfg.term     = req_term;
        cfg.half_drv = req_half_drv;
        cfg.dll_off  = req_dll_off;
        al_bad       = (req_al > AL_MAX) && (req_ocd != OCD_ADJ);
        is_dflt      = (req_ocd == OCD_DFLT);
        wr_seen      = !cs_n && !ras_n && !cas_n && !we_n && (ba == BA_EMR1);
    end

    emr_fsm #(.T_MRD(T_MRD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .banks_idle(banks_idle),
        .cke(cke), .al_bad(al_bad), .is_dflt(is_dflt), .ready_o(req_ready),
        .fire_new(fire_new), .fire_exit(fire_exit), .err(req_err)
    );

    emr_drv #(.ADDR_W(ADDR_W)) u_drv (
        .clk(clk), .rst_n(rst_n), .fire_new(fire_new), .fire_exit(fire_exit),
        .req_cfg(cfg), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );

    emr_dll #(.DLL_LOCK(DLL_LOCK)) u_dll (
        .clk(clk), .rst_n(rst_n), .wr(wr_seen), .wr_dll_off(addr[0]),
        .sr_enter(sr_enter), .sr_exit(sr_exit), .rd_permit(rd_permit)
    );

endmodule

// File: tb/sim_emr_seq.sv
module sim_emr_seq;

    localparam int T_MRD = 2;
    localparam int LOCK  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_dll_off = 1'b0, req_half_drv = 1'b0;
    logic [1:0] req_term = '0;
    logic [2:0] req_al = '0, req_ocd = '0;
    logic req_dqsn_off = 1'b0, req_qoff = 1'b0;
    logic banks_idle = 1'b1, cke = 1'b1, sr_enter = 1'b0, sr_exit = 1'b0;
    logic req_ready, req_err, rd_permit, cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba;
    logic [12:0] addr;

    int n_chk = 0, n_fail = 0;
    string phase = "R10";

    always #2 clk = ~clk;

    emr_seq #(.ADDR_W(13), .T_MRD(T_MRD), .DLL_LOCK(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dll_off(req_dll_off), .req_half_drv(req_half_drv), .req_term(req_term),
        .req_al(req_al), .req_ocd(req_ocd), .req_dqsn_off(req_dqsn_off), .req_qoff(req_qoff),
        .banks_idle(banks_idle), .cke(cke), .sr_enter(sr_enter), .sr_exit(sr_exit),
        .req_err(req_err), .rd_permit(rd_permit), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr)
    );

    // ---------------- behavioural reference ----------------
    int busy = 0, m_lock = 0;
    bit pend = 0, e_mrs = 0, e_err = 0, m_on = 0, m_prog = 0;
    logic [12:0] e_addr = '0;
    bit h_dl = 1, h_hd = 0, h_dq = 0, h_qo = 0;
    logic [1:0] h_rt = '0;
    logic [2:0] h_al = '0, h_oc = '0;

    function automatic logic [12:0] mpack(bit dl, bit hd, logic [1:0] rt, logic [2:0] al,
                                          logic [2:0] oc, bit dq, bit qo);
        return {qo, 1'b0, dq, oc, rt[1], al, rt[0], hd, dl};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            busy = 0; pend = 0; e_mrs = 0; e_err = 0; e_addr = '0;
            m_on = 0; m_prog = 0; m_lock = 0;
            h_dl = 1; h_hd = 0; h_dq = 0; h_qo = 0; h_rt = '0; h_al = '0; h_oc = '0;
        end else begin
            bit p_mrs, p_a0;
            p_mrs = e_mrs; p_a0 = e_addr[0];
            e_mrs = 0; e_err = 0; e_addr = '0;
            if (busy > 0) begin
                busy--;
                if (busy == 0 && pend) begin
                    pend = 0; h_oc = 3'b000; e_mrs = 1; busy = T_MRD;
                    e_addr = mpack(h_dl, h_hd, h_rt, h_al, h_oc, h_dq, h_qo);
                end
            end else if (req_valid && banks_idle && cke) begin
                if (req_al > 5 && req_ocd != 3'b100) e_err = 1;
                else begin
                    if (req_ocd != 3'b100) h_al = req_al;
                    h_dl = req_dll_off; h_hd = req_half_drv; h_rt = req_term;
                    h_oc = req_ocd; h_dq = req_dqsn_off; h_qo = req_qoff;
                    e_mrs = 1; busy = T_MRD; pend = (req_ocd == 3'b111);
                    e_addr = mpack(h_dl, h_hd, h_rt, h_al, h_oc, h_dq, h_qo);
                end
            end
            if (m_lock > 0) m_lock--;
            if (sr_enter) m_on = 0;
            else if (sr_exit && m_prog) begin m_on = 1; m_lock = LOCK - 1; end
            else if (p_mrs) begin
                m_prog = !p_a0;
                if (p_a0) m_on = 0;
                else if (!m_on) begin m_on = 1; m_lock = LOCK - 1; end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string sig,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [phase %s] %s actual=%0h expected=%0h", tag, phase, sig, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [5:0] ep, ap;
        ep = e_mrs ? 6'b0000_01 : 6'b0111_00;
        ap = {cs_n, ras_n, cas_n, we_n, ba};
        check(ap === ep, "R1", "cmd pins", 32'(ap), 32'(ep));
        check(addr === e_addr, "R2", "addr", 32'(addr), 32'(e_addr));
        check(req_ready === (busy == 0 && banks_idle && cke), "R3", "req_ready",
              32'(req_ready), 32'(busy == 0 && banks_idle && cke));
        check(req_err === e_err, "R5", "req_err", 32'(req_err), 32'(e_err));
        check(rd_permit === (m_on && m_lock == 0), "R8", "rd_permit",
              32'(rd_permit), 32'(m_on && m_lock == 0));
    end

    // ---------------- stimulus ----------------
    task automatic put(bit dl, bit hd, logic [1:0] rt, logic [2:0] al, logic [2:0] oc,
                       bit dq, bit qo);
        req_dll_off = dl; req_half_drv = hd; req_term = rt; req_al = al;
        req_ocd = oc; req_dqsn_off = dq; req_qoff = qo; req_valid = 1'b1;
    endtask

    task automatic take();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk); #1 req_valid = 1'b0;
    endtask

    task automatic send(bit dl, bit hd, logic [1:0] rt, logic [2:0] al, logic [2:0] oc,
                        bit dq, bit qo);
        @(posedge clk); #1 put(dl, hd, rt, al, oc, dq, qo);
        take();
        repeat (T_MRD + 3) @(posedge clk);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3); #1 rst_n = 1'b1;            // R10 reset state compared every cycle
        idle(3);
        phase = "R1";  send(0, 1, 2'b10, 3'd3, 3'b000, 1, 0);
        phase = "R8";  idle(LOCK + 5);      // lock window edge
        phase = "R2";  send(0, 0, 2'b01, 3'd5, 3'b001, 0, 1);
        send(0, 1, 2'b11, 3'd0, 3'b010, 1, 1);
        phase = "R3";
        @(posedge clk); #1 banks_idle = 1'b0; put(0, 0, 2'b00, 3'd2, 3'b000, 0, 0);
        idle(4); #1 banks_idle = 1'b1; cke = 1'b0;
        idle(3); #1 cke = 1'b1;
        take(); idle(T_MRD + 2);
        phase = "R4";
        @(posedge clk); #1 put(0, 0, 2'b01, 3'd1, 3'b000, 0, 0); take();
        #0 put(0, 1, 2'b10, 3'd4, 3'b000, 0, 0); take(); idle(T_MRD + 2);
        phase = "R5";  send(0, 0, 2'b00, 3'd6, 3'b000, 0, 0);
        send(0, 0, 2'b00, 3'd7, 3'b001, 0, 0);
        phase = "R6";  send(0, 1, 2'b11, 3'd2, 3'b111, 1, 0);
        idle(T_MRD + 2);
        phase = "R7";  send(0, 0, 2'b10, 3'd7, 3'b100, 0, 0);
        phase = "R11"; send(1, 0, 2'b00, 3'd1, 3'b000, 0, 0);
        idle(4);
        phase = "R8";  send(0, 0, 2'b00, 3'd1, 3'b000, 0, 0);
        idle(LOCK + 3);
        phase = "R9";
        @(posedge clk); #1 sr_enter = 1'b1;
        @(posedge clk); #1 sr_enter = 1'b0;
        idle(10); #1 sr_exit = 1'b1;
        @(posedge clk); #1 sr_exit = 1'b0;
        idle(LOCK + 5);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule